// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

A single-channel pulse-width modulator. An 8-bit timer advances once every four input clocks times a selectable prescale factor (1, 4 or 16). It restarts after it reaches a programmable period limit. The output rises at the start of each period. It falls when a 10-bit duty value equals the timer extended by a 2-bit fine count, so the duty resolution is one prescale unit of input clocks and four times finer than a timer step.

The duty value is written as an 8-bit upper part and a 2-bit lower part through a small write port. Both parts land in a buffer that may be rewritten at any time. The buffer is copied into an active shadow only at the period boundary, so a period in progress is never disturbed. The shadow is brought out for readback. A postscaler divides the period boundaries into a separate one-clock event output. It has no influence on the PWM frequency.

Top module: `pwm_gen`

## Requirements
- R1: After reset `pwm_o` and `period_evt_o` are low, `shadow_duty_o` is 0 and the period limit is 0xFF. At prescale 1 the first boundary after enabling comes 1024 clocks later.
- R2: A period lasts (L+1)·4·P input clocks, where L is the period limit and P is the prescale factor. The prescale field code 0 selects 1, code 1 selects 4, and codes 2 and 3 select 16.
- R3: For a latched duty D with 0 < D < 4·(L+1), `pwm_o` is high for exactly the first D·P clocks of each period and low for the rest.
- R4: A latched duty of 0 keeps `pwm_o` low for the whole period, including its first clock.
- R5: A latched duty D ≥ 4·(L+1) keeps `pwm_o` high for the whole period.
- R6: Duty writes change only the buffer. `shadow_duty_o` and the output waveform take the new value at the next period boundary, and the period in progress finishes with the old value.
- R7: With postscale field N (0..15), `period_evt_o` is a one-clock pulse on every (N+1)-th period boundary. It goes high in the first clock of the new period.
- R8: While the enable bit is 0, `pwm_o` is low, no events occur and the timebase is held at zero. After re-enabling, `pwm_o` stays low until the first boundary, which comes one full period later.
- R9: Write map (`wr_addr_i`): 0 is the period limit; 1 is duty bits 9:2; 2 is duty bits 1:0 from data bits 1:0; 3 is control, with bit 0 enable, bits 2:1 prescale code and bits 6:3 postscale field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | 8 | Write data |
| pwm_o | output | 1 | PWM output |
| period_evt_o | output | 1 | Postscaled period event pulse |
| shadow_duty_o | output | 10 | Active (latched) duty value |

## Verification
The assertions check these rules on every cycle: the output rises only in the clock after a period boundary and only with a nonzero shadow; the shadow holds between boundaries; the timer holds between ticks and restarts at zero; disabling clears the output and counters; and each event is a single clock that follows a boundary. Only the bench scenarios can show the exact high time D·P at each prescale setting, the period length for several limits, the saturation at zero and over-length duty, the one-period delay of a new duty, and the postscale spacing.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    PS_DIV1   = 2'b00,
    PS_DIV4   = 2'b01,
    PS_DIV16  = 2'b10,
    PS_DIV16B = 2'b11
  } prescale_e;

  localparam logic [1:0] ADDR_PERIOD  = 2'd0;
  localparam logic [1:0] ADDR_DUTY_HI = 2'd1;
  localparam logic [1:0] ADDR_DUTY_LO = 2'd2;
  localparam logic [1:0] ADDR_CTRL    = 2'd3;

  localparam int unsigned SUB_W = 2;
  localparam int unsigned PRE_W = 4;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int unsigned TMR_W  = 8,
  parameter int unsigned POST_W = 4,
  localparam int unsigned DUTY_W = TMR_W + SUB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [TMR_W-1:0]  wr_data_i,
  output logic [TMR_W-1:0]  period_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic              en_o,
  output prescale_e         psel_o,
  output logic [POST_W-1:0] post_o
);
  logic [TMR_W-1:0] duty_hi_q;
  logic [SUB_W-1:0] duty_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_o  <= '1;
      duty_hi_q <= '0;
      duty_lo_q <= '0;
      en_o      <= 1'b0;
      psel_o    <= PS_DIV1;
      post_o    <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_PERIOD:  period_o  <= wr_data_i;
        ADDR_DUTY_HI: duty_hi_q <= wr_data_i;
        ADDR_DUTY_LO: duty_lo_q <= wr_data_i[SUB_W-1:0];
        default: begin
          en_o   <= wr_data_i[0];
          psel_o <= prescale_e'(wr_data_i[2:1]);
          post_o <= wr_data_i[3 +: POST_W];
        end
      endcase
    end
  end

  assign duty_o = {duty_hi_q, duty_lo_q};
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_pkg::*;
#(
  parameter int unsigned TMR_W = 8,
  localparam int unsigned CNT_W = TMR_W + SUB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  prescale_e        psel_i,
  input  logic [TMR_W-1:0] period_i,
  output logic             bnd_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [SUB_W-1:0] ph_q, ph_d;
  logic [PRE_W-1:0] pre_q, pre_d, pre_lim;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             tick;
  logic [SUB_W-1:0] sub_d;

  always_comb begin
    unique case (psel_i)
      PS_DIV1: pre_lim = PRE_W'(0);
      PS_DIV4: pre_lim = PRE_W'(3);
      default: pre_lim = PRE_W'(15);
    endcase
  end

  assign tick  = en_i && (&ph_q) && (pre_q >= pre_lim);
  assign bnd_o = tick && (tmr_q == period_i);

  always_comb begin
    ph_d  = en_i ? ph_q + 1'b1 : '0;
    pre_d = pre_q;
    if (!en_i)
      pre_d = '0;
    else if (&ph_q)
      pre_d = (pre_q >= pre_lim) ? '0 : pre_q + 1'b1;
    tmr_d = tmr_q;
    if (!en_i)
      tmr_d = '0;
    else if (tick)
      tmr_d = (tmr_q == period_i) ? '0 : tmr_q + 1'b1;
    // fine step is one prescale unit of input clocks
    unique case (psel_i)
      PS_DIV1: sub_d = ph_d;
      PS_DIV4: sub_d = pre_d[1:0];
      default: sub_d = pre_d[3:2];
    endcase
  end

  assign cnt_nxt_o = {tmr_d, sub_d};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= '0;
      pre_q <= '0;
      tmr_q <= '0;
    end else begin
      ph_q  <= ph_d;
      pre_q <= pre_d;
      tmr_q <= tmr_d;
    end
  end

  a_r8_hold_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (tmr_q == '0 && ph_q == '0 && pre_q == '0));
  a_r2_tmr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick) |=> $stable(tmr_q));
  a_r2_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd_o |=> (tmr_q == '0));
endmodule

// File: rtl/pwm_duty.sv
module pwm_duty #(
  parameter int unsigned DUTY_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bnd_i,
  input  logic [DUTY_W-1:0] cnt_nxt_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic [DUTY_W-1:0] shadow_o,
  output logic              pwm_o
);
  logic [DUTY_W-1:0] shadow_q;
  logic              pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      pwm_q    <= 1'b0;
    end else begin
      if (bnd_i) shadow_q <= duty_i;
      if (!en_i)
        pwm_q <= 1'b0;
      else if (bnd_i)
        pwm_q <= |duty_i;
      else if (cnt_nxt_i == shadow_q)
        pwm_q <= 1'b0;
    end
  end

  assign shadow_o = shadow_q;
  assign pwm_o    = pwm_q;

  a_r3_rise_on_bnd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_q) |-> $past(bnd_i));
  a_r4_rise_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_q) |-> (shadow_q != '0));
  a_r6_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd_i |=> $stable(shadow_q));
  a_r8_off_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_q);
endmodule

// File: rtl/pwm_postscale.sv
module pwm_postscale #(
  parameter int unsigned POST_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bnd_i,
  input  logic [POST_W-1:0] ratio_i,
  output logic              evt_o
);
  logic [POST_W-1:0] cnt_q;
  logic              evt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      evt_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (bnd_i) begin
        if (cnt_q >= ratio_i) begin
          cnt_q <= '0;
          evt_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign evt_o = evt_q;

  a_r7_evt_after_bnd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> $past(bnd_i));
  a_r7_single_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |=> !evt_q);
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_pkg::*;
#(
  parameter int unsigned TMR_W  = 8,
  parameter int unsigned POST_W = 4,
  localparam int unsigned DUTY_W = TMR_W + SUB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [TMR_W-1:0]  wr_data_i,
  output logic              pwm_o,
  output logic              period_evt_o,
  output logic [DUTY_W-1:0] shadow_duty_o
);
  logic [TMR_W-1:0]  period;
  logic [DUTY_W-1:0] duty_buf;
  logic [DUTY_W-1:0] cnt_nxt;
  logic [POST_W-1:0] post;
  logic              en;
  logic              bnd;
  prescale_e         psel;

  pwm_regs #(.TMR_W(TMR_W), .POST_W(POST_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .period_o(period), .duty_o(duty_buf), .en_o(en),
    .psel_o(psel), .post_o(post)
  );

  pwm_timebase #(.TMR_W(TMR_W)) u_tb (
    .clk_i, .rst_ni, .en_i(en), .psel_i(psel), .period_i(period),
    .bnd_o(bnd), .cnt_nxt_o(cnt_nxt)
  );

  pwm_duty #(.DUTY_W(DUTY_W)) u_duty (
    .clk_i, .rst_ni, .en_i(en), .bnd_i(bnd), .cnt_nxt_i(cnt_nxt),
    .duty_i(duty_buf), .shadow_o(shadow_duty_o), .pwm_o(pwm_o)
  );

  pwm_postscale #(.POST_W(POST_W)) u_post (
    .clk_i, .rst_ni, .en_i(en), .bnd_i(bnd), .ratio_i(post),
    .evt_o(period_evt_o)
  );
endmodule

// File: tb/tb_pwm_gen.sv
`timescale 1ns/1ps
module tb_pwm_gen;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm, evt;
  logic [9:0] shadow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit    exp_v[$];
  string exp_t[$];

  always #2.5 clk = ~clk;

  pwm_gen dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pwm_o(pwm), .period_evt_o(evt), .shadow_duty_o(shadow)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: scoreboard pop, sampled 2 ns after each rising edge
  always @(posedge clk) begin
    bit e;
    string t;
    #2;
    if (exp_v.size() != 0) begin
      e = exp_v.pop_front();
      t = exp_t.pop_front();
      chk(pwm == e, t, int'(pwm), int'(e));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_duty(input int d);
    wr(2'd1, 8'(d >> 2));
    wr(2'd2, 8'(d & 3));
  endtask

  task automatic set_ctrl(input bit en, input int ps, input int post);
    wr(2'd3, 8'((post << 3) | (ps << 1) | int'(en)));
  endtask

  task automatic wait_evt(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!evt && n < 5000);
    if (!evt) chk(1'b0, "evt timeout", n, 0);
  endtask

  // driver: called in first clock of a period; checks clock 0, queues the rest
  task automatic expect_period(input int d, input int p, input int pr, input string tag);
    int pclk, hi;
    pclk = (pr + 1) * 4 * p;
    hi   = d * p;
    chk(pwm == (hi > 0), {tag, " clk0"}, int'(pwm), int'(hi > 0));
    for (int k = 1; k < pclk; k++) begin
      exp_v.push_back(k < hi);
      exp_t.push_back(tag);
    end
  endtask

  task automatic drain();
    while (exp_v.size() != 0) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(pwm == 1'b0, "R1 pwm reset", int'(pwm), 0);
    chk(evt == 1'b0, "R1 evt reset", int'(evt), 0);
    chk(shadow == 10'd0, "R1 shadow reset", int'(shadow), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1/R2: default limit 0xFF at prescale 1
    set_ctrl(1'b1, 0, 0);
    wait_evt(n);
    chk(n == 1024, "R1 R2 default period", n, 1024);
    chk(pwm == 1'b0, "R4 zero buffer", int'(pwm), 0);

    // R9/R3: limit 3, duty 6
    wr(2'd0, 8'd3);
    wr_duty(6);
    wait_evt(n);
    chk(shadow == 10'd6, "R6 shadow load", int'(shadow), 6);
    expect_period(6, 1, 3, "R3 p1 d6");
    wait_evt(n);
    chk(n == 16, "R2 limit3 p1", n, 16);
    expect_period(6, 1, 3, "R6 old duty");
    wr_duty(0);
    chk(shadow == 10'd6, "R6 shadow held", int'(shadow), 6);
    wait_evt(n);
    chk(shadow == 10'd0, "R6 shadow new", int'(shadow), 0);
    expect_period(0, 1, 3, "R4 zero duty");
    wr_duty(16);
    wait_evt(n);
    expect_period(16, 1, 3, "R5 duty eq len");
    wr_duty(1023);
    wait_evt(n);
    expect_period(1023, 1, 3, "R5 duty max");
    drain();

    // prescale 4
    set_ctrl(1'b0, 0, 0);
    wr_duty(5);
    set_ctrl(1'b1, 1, 0);
    wait_evt(n);
    expect_period(5, 4, 3, "R3 p4 d5");
    wait_evt(n);
    chk(n == 64, "R2 p4", n, 64);
    drain();

    // prescale 16, code 2
    set_ctrl(1'b0, 0, 0);
    wr(2'd0, 8'd1);
    wr_duty(3);
    set_ctrl(1'b1, 2, 0);
    wait_evt(n);
    expect_period(3, 16, 1, "R3 p16 d3");
    wait_evt(n);
    chk(n == 128, "R2 p16", n, 128);
    drain();

    // postscale field 2 -> every third boundary
    set_ctrl(1'b0, 0, 0);
    wr(2'd0, 8'd3);
    wr_duty(6);
    set_ctrl(1'b1, 0, 2);
    wait_evt(n);
    @(negedge clk);
    chk(evt == 1'b0, "R7 pulse width", int'(evt), 0);
    wait_evt(n);
    chk(n == 47, "R7 postscale spacing", n, 47);
    chk(pwm == 1'b1, "R7 evt at period start", int'(pwm), 1);

    // R8: disable then re-enable
    set_ctrl(1'b0, 0, 2);
    begin
      bit bad = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (pwm || evt) bad = 1'b1;
      end
      chk(!bad, "R8 disabled quiet", int'(bad), 0);
    end
    set_ctrl(1'b1, 0, 0);
    chk(pwm == 1'b0, "R8 low until boundary", int'(pwm), 0);
    wait_evt(n);
    chk(n == 16, "R8 restart from zero", n, 16);
    expect_period(6, 1, 3, "R8 R3 after enable");
    drain();
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule